// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds the fetch program counter, a PC-valid flag, a per-thread instruction sequence counter and a recorded block stage for every hardware thread of an in-order pipeline. When the fetch stage asks for a thread whose PC is valid, the block returns the current PC and a sequence number in the same cycle, then steps the PC by one 4-byte instruction and bumps that thread's counter. A thread whose PC is not valid gets a stall instead of an address.

Branch reports from a later pipeline stage come back into the block. A return that the predictor could not supply a target for (a control instruction that is a return and is not predicted taken) blocks fetch for its thread. The block pulses a block line for the reporting stage and that thread, and it remembers that stage. A control instruction that is predicted taken produces an outgoing squash request tagged with its thread, stage and sequence number. Squash commands arrive on several lanes per cycle. For each thread, only the oldest one (the lowest sequence number) is taken. It redirects the PC and pulses an unblock line at the remembered stage, unless it was caused by a fault, in which case the thread stays stalled until a trap supplies the PC. Trap, activate and deactivate commands complete the thread control.

Top module: `fetch_pc_seq`

## Requirements
- R1: After reset every thread's PC is invalid, so a fetch request to any thread returns fetch_vld=0, fetch_stall=1 and zero on fetch_pc and fetch_seq.
- R2: A fetch request to a thread with a valid PC, and no accepted squash for that thread in the same cycle, returns that PC and the thread's sequence number in the same cycle (fetch_vld=1, fetch_stall=0). From the next cycle the PC is 4 higher and the sequence number is 1 higher.
- R3: A fetch request to a thread whose PC is invalid gives fetch_stall=1, fetch_vld=0 and zero outputs. It changes neither the PC nor the sequence number.
- R4: A branch report with br_ctrl=1, br_ret=1 and br_taken=0 pulses bit br_stage*THREADS+br_tid of blk_out in the same cycle. From the next cycle the thread's PC is invalid and br_stage is its recorded block stage.
- R5: A branch report with br_ctrl=1 and br_taken=1 sets sqo_vld in the same cycle, with sqo_tid, sqo_stage and sqo_seq equal to the report's thread, stage and sequence number. A report with br_ctrl=0 drives neither sqo_vld nor blk_out.
- R6: Among the valid squash lanes that name the same thread in one cycle, only the lane with the lowest sequence number takes effect. On a tie the lowest-numbered lane wins.
- R7: An accepted squash of kind 0 (fault) clears the thread's PC-valid flag and pulses no unblock.
- R8: An accepted squash of kind 1 (control) loads the lane's target into the PC and sets PC-valid. In the same cycle it pulses bit recorded_stage*THREADS+tid of unblk_out.
- R9: An accepted squash of kind 2 or 3 (sequential) loads the lane's instruction PC plus 4 and sets PC-valid, with the same unblock pulse as R8.
- R10: A trap loads trap_pc into the thread's PC and sets PC-valid.
- R11: Deactivating a thread clears its PC-valid flag and resets its recorded block stage to 0, so a later non-fault squash on it pulses the unblock bit for stage 0.
- R12: When a squash is accepted for the thread that fetch requests in the same cycle, the fetch stalls and the PC and sequence number do not advance because of it.
- R13: Activation loads act_pc and sets PC-valid, and each thread keeps its own sequence counter. On one thread, later commands in this order override earlier ones: fetch advance, block, squash, trap, activate, deactivate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request |
| fetch_tid | input | TID_W | Thread to fetch for |
| fetch_vld | output | 1 | Fetch returned an address |
| fetch_stall | output | 1 | Fetch refused, PC not usable |
| fetch_pc | output | PC_W | Returned PC (0 when not valid) |
| fetch_seq | output | SEQ_W | Returned sequence number (0 when not valid) |
| br_vld | input | 1 | Branch report valid |
| br_tid | input | TID_W | Reported thread |
| br_stage | input | STG_W | Reporting stage |
| br_seq | input | SEQ_W | Sequence number of reported instruction |
| br_ctrl | input | 1 | Instruction is a control instruction |
| br_ret | input | 1 | Instruction is a return |
| br_taken | input | 1 | Predicted taken |
| blk_out | output | STAGES*THREADS | Block pulse, bit stage*THREADS+tid |
| sqo_vld | output | 1 | Outgoing squash request |
| sqo_tid | output | TID_W | Thread of the outgoing squash |
| sqo_stage | output | STG_W | Stage of the outgoing squash |
| sqo_seq | output | SEQ_W | Sequence number of the outgoing squash |
| sq_vld | input | LANES | Squash lane valid |
| sq_tid | input | LANES x TID_W | Squash lane thread |
| sq_seq | input | LANES x SEQ_W | Squash lane sequence number |
| sq_kind | input | LANES x 2 | 0 fault, 1 control, 2/3 sequential |
| sq_target | input | LANES x PC_W | Predicted target for control squash |
| sq_pc | input | LANES x PC_W | Instruction PC for sequential squash |
| unblk_out | output | STAGES*THREADS | Unblock pulse, bit stage*THREADS+tid |
| trap_vld | input | 1 | Trap command |
| trap_tid | input | TID_W | Trap thread |
| trap_pc | input | PC_W | Architectural PC from the trap |
| act_vld | input | 1 | Activate command |
| act_tid | input | TID_W | Activated thread |
| act_pc | input | PC_W | Starting PC |
| deact_vld | input | 1 | Deactivate command |
| deact_tid | input | TID_W | Deactivated thread |

## Verification
A wrong PC or a missed advance shows on fetch_pc at the next fetch request for that thread. A stuck or wrongly cleared valid flag shows as a wrong fetch_stall in that same cycle. A wrongly recorded block stage stays hidden until the next non-fault squash on the thread, when the unblock pulse lands on the wrong bit of unblk_out. A faulty oldest-squash choice shows as the wrong redirect target at the first fetch after the squash.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int unsigned INSN_BYTES = 4;

    // Cause of an incoming squash on one lane
    typedef enum logic [1:0] {
        SQK_FAULT = 2'd0,
        SQK_CTRL  = 2'd1,
        SQK_SEQ   = 2'd2,
        SQK_SEQ2  = 2'd3
    } sq_kind_e;

    function automatic logic kind_unblocks(input logic [1:0] k);
        return sq_kind_e'(k) != SQK_FAULT;
    endfunction

endpackage

// File: rtl/fps_squash_pick.sv
module fps_squash_pick #(
    parameter int LANES   = 2,
    parameter int THREADS = 4,
    parameter int TID_W   = 2,
    parameter int SEQ_W   = 16,
    parameter int LANE_W  = 1
) (
    input  logic [LANES-1:0]              sq_vld,
    input  logic [LANES-1:0][TID_W-1:0]   sq_tid,
    input  logic [LANES-1:0][SEQ_W-1:0]   sq_seq,
    output logic [THREADS-1:0]            win_hit,
    output logic [THREADS-1:0][LANE_W-1:0] win_lane
);
    logic [THREADS-1:0][SEQ_W-1:0] best_seq;

    // Lanes are scanned in order; a later lane only replaces the winner of
    // its thread when strictly older (lower sequence number).
    always_comb begin
        win_hit  = '0;
        win_lane = '0;
        best_seq = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sq_vld[l]) begin
                if (!win_hit[sq_tid[l]] || (sq_seq[l] < best_seq[sq_tid[l]])) begin
                    win_hit[sq_tid[l]]  = 1'b1;
                    best_seq[sq_tid[l]] = sq_seq[l];
                    win_lane[sq_tid[l]] = LANE_W'(l);
                end
            end
        end
    end
endmodule

// File: rtl/fps_thread_state.sv
module fps_thread_state
    import fps_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    parameter int STG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_hit,
    input  logic             blk_hit,
    input  logic [STG_W-1:0] blk_stage,
    input  logic             sq_hit,
    input  logic [1:0]       sq_kind,
    input  logic [PC_W-1:0]  sq_target,
    input  logic [PC_W-1:0]  sq_pc,
    input  logic             trap_hit,
    input  logic [PC_W-1:0]  trap_pc,
    input  logic             act_hit,
    input  logic [PC_W-1:0]  act_pc,
    input  logic             deact_hit,
    output logic [PC_W-1:0]  pc_q,
    output logic             valid_q,
    output logic [SEQ_W-1:0] seq_q,
    output logic [STG_W-1:0] bstage_q
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             valid;
        logic [SEQ_W-1:0] seq;
        logic [STG_W-1:0] bstage;
    } ctx_t;

    ctx_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (fetch_hit) begin
            nxt.pc  = cur.pc + PC_W'(INSN_BYTES);
            nxt.seq = cur.seq + SEQ_W'(1);
        end
        if (blk_hit) begin
            nxt.valid  = 1'b0;
            nxt.bstage = blk_stage;
        end
        if (sq_hit) begin
            unique case (sq_kind_e'(sq_kind))
                SQK_FAULT: nxt.valid = 1'b0;
                SQK_CTRL: begin
                    nxt.pc    = sq_target;
                    nxt.valid = 1'b1;
                end
                default: begin
                    nxt.pc    = sq_pc + PC_W'(INSN_BYTES);
                    nxt.valid = 1'b1;
                end
            endcase
        end
        if (trap_hit) begin
            nxt.pc    = trap_pc;
            nxt.valid = 1'b1;
        end
        if (act_hit) begin
            nxt.pc    = act_pc;
            nxt.valid = 1'b1;
        end
        if (deact_hit) begin
            nxt.valid  = 1'b0;
            nxt.bstage = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign pc_q     = cur.pc;
    assign valid_q  = cur.valid;
    assign seq_q    = cur.seq;
    assign bstage_q = cur.bstage;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && !sq_hit && !trap_hit && !act_hit && !deact_hit)
        |=> (pc_q == $past(pc_q) + PC_W'(INSN_BYTES)) && (seq_q == $past(seq_q) + SEQ_W'(1)));

    // R4
    ret_block_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_hit && !sq_hit && !trap_hit && !act_hit && !deact_hit)
        |=> !valid_q && (bstage_q == $past(blk_stage)));

    // R10
    trap_load_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_hit && !act_hit && !deact_hit) |=> valid_q && (pc_q == $past(trap_pc)));

    // R11
    deact_clear_chk: assert property (@(posedge clk) disable iff (rst)
        deact_hit |=> !valid_q && (bstage_q == '0));
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
    import fps_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int STAGES  = 5,
    parameter int LANES   = 2,
    parameter int PC_W    = 32,
    parameter int SEQ_W   = 16,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int STG_W  = (STAGES > 1) ? $clog2(STAGES) : 1,
    localparam int NBIT   = STAGES * THREADS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fetch_req,
    input  logic [TID_W-1:0]              fetch_tid,
    output logic                          fetch_vld,
    output logic                          fetch_stall,
    output logic [PC_W-1:0]               fetch_pc,
    output logic [SEQ_W-1:0]              fetch_seq,
    input  logic                          br_vld,
    input  logic [TID_W-1:0]              br_tid,
    input  logic [STG_W-1:0]              br_stage,
    input  logic [SEQ_W-1:0]              br_seq,
    input  logic                          br_ctrl,
    input  logic                          br_ret,
    input  logic                          br_taken,
    output logic [NBIT-1:0]               blk_out,
    output logic                          sqo_vld,
    output logic [TID_W-1:0]              sqo_tid,
    output logic [STG_W-1:0]              sqo_stage,
    output logic [SEQ_W-1:0]              sqo_seq,
    input  logic [LANES-1:0]              sq_vld,
    input  logic [LANES-1:0][TID_W-1:0]   sq_tid,
    input  logic [LANES-1:0][SEQ_W-1:0]   sq_seq,
    input  logic [LANES-1:0][1:0]         sq_kind,
    input  logic [LANES-1:0][PC_W-1:0]    sq_target,
    input  logic [LANES-1:0][PC_W-1:0]    sq_pc,
    output logic [NBIT-1:0]               unblk_out,
    input  logic                          trap_vld,
    input  logic [TID_W-1:0]              trap_tid,
    input  logic [PC_W-1:0]               trap_pc,
    input  logic                          act_vld,
    input  logic [TID_W-1:0]              act_tid,
    input  logic [PC_W-1:0]               act_pc,
    input  logic                          deact_vld,
    input  logic [TID_W-1:0]              deact_tid
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [THREADS-1:0]              win_hit;
    logic [THREADS-1:0][LANE_W-1:0]  win_lane;
    logic [THREADS-1:0]              fetch_hit;
    logic [THREADS-1:0]              t_valid;
    logic [THREADS-1:0][PC_W-1:0]    t_pc;
    logic [THREADS-1:0][SEQ_W-1:0]   t_seq;
    logic [THREADS-1:0][STG_W-1:0]   t_bstage;
    logic [THREADS-1:0][1:0]         w_kind;

    logic ret_block;
    assign ret_block = br_vld && br_ctrl && br_ret && !br_taken;

    fps_squash_pick #(
        .LANES(LANES), .THREADS(THREADS), .TID_W(TID_W),
        .SEQ_W(SEQ_W), .LANE_W(LANE_W)
    ) u_pick (
        .sq_vld  (sq_vld),
        .sq_tid  (sq_tid),
        .sq_seq  (sq_seq),
        .win_hit (win_hit),
        .win_lane(win_lane)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        assign fetch_hit[t] = fetch_req && (fetch_tid == TID_W'(t)) && t_valid[t] && !win_hit[t];
        assign w_kind[t]    = sq_kind[win_lane[t]];

        fps_thread_state #(.PC_W(PC_W), .SEQ_W(SEQ_W), .STG_W(STG_W)) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .fetch_hit(fetch_hit[t]),
            .blk_hit  (ret_block && (br_tid == TID_W'(t))),
            .blk_stage(br_stage),
            .sq_hit   (win_hit[t]),
            .sq_kind  (w_kind[t]),
            .sq_target(sq_target[win_lane[t]]),
            .sq_pc    (sq_pc[win_lane[t]]),
            .trap_hit (trap_vld && (trap_tid == TID_W'(t))),
            .trap_pc  (trap_pc),
            .act_hit  (act_vld && (act_tid == TID_W'(t))),
            .act_pc   (act_pc),
            .deact_hit(deact_vld && (deact_tid == TID_W'(t))),
            .pc_q     (t_pc[t]),
            .valid_q  (t_valid[t]),
            .seq_q    (t_seq[t]),
            .bstage_q (t_bstage[t])
        );

        for (genvar s = 0; s < STAGES; s++) begin : g_stg
            assign blk_out[s*THREADS+t]   = ret_block && (br_tid == TID_W'(t))
                                            && (br_stage == STG_W'(s));
            assign unblk_out[s*THREADS+t] = win_hit[t] && kind_unblocks(w_kind[t])
                                            && (t_bstage[t] == STG_W'(s));
        end
    end

    assign fetch_vld   = |fetch_hit;
    assign fetch_stall = fetch_req && !fetch_vld;
    assign fetch_pc    = fetch_vld ? t_pc[fetch_tid]  : '0;
    assign fetch_seq   = fetch_vld ? t_seq[fetch_tid] : '0;

    assign sqo_vld   = br_vld && br_ctrl && br_taken;
    assign sqo_tid   = br_tid;
    assign sqo_stage = br_stage;
    assign sqo_seq   = br_seq;
endmodule

// File: tb/test_fetch_pc_seq.sv
module test_fetch_pc_seq;
    localparam int CLK_P = 10;
    localparam int T = 4, S = 5, L = 2, PW = 32, SW = 16;

    logic clk = 1'b0, rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic fetch_req; logic [1:0] fetch_tid;
    logic fetch_vld, fetch_stall; logic [PW-1:0] fetch_pc; logic [SW-1:0] fetch_seq;
    logic br_vld; logic [1:0] br_tid; logic [2:0] br_stage; logic [SW-1:0] br_seq;
    logic br_ctrl, br_ret, br_taken;
    logic [S*T-1:0] blk_out, unblk_out;
    logic sqo_vld; logic [1:0] sqo_tid; logic [2:0] sqo_stage; logic [SW-1:0] sqo_seq;
    logic [L-1:0] sq_vld; logic [L-1:0][1:0] sq_tid; logic [L-1:0][SW-1:0] sq_seq;
    logic [L-1:0][1:0] sq_kind; logic [L-1:0][PW-1:0] sq_target, sq_pc;
    logic trap_vld; logic [1:0] trap_tid; logic [PW-1:0] trap_pc;
    logic act_vld; logic [1:0] act_tid; logic [PW-1:0] act_pc;
    logic deact_vld; logic [1:0] deact_tid;

    fetch_pc_seq i_fetch_pc_seq (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [PW-1:0] mpc[T]; bit mval[T]; logic [SW-1:0] mseq[T]; logic [2:0] mbst[T];
    bit ehit[T]; int elane[T]; logic [SW-1:0] ebest[T]; bit efv;

    // explicit directed expectations
    bit x_en; bit x_vld; logic [PW-1:0] x_pc; bit x_seq_en; logic [SW-1:0] x_seq;
    bit x_unb_en; logic [S*T-1:0] x_unb; string x_req;

    task automatic chk(string r, logic [63:0] a, logic [63:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, a, e);
        end
    endtask

    task automatic clear_in();
        fetch_req = 0; fetch_tid = 0; br_vld = 0; br_tid = 0; br_stage = 0; br_seq = 0;
        br_ctrl = 0; br_ret = 0; br_taken = 0; sq_vld = '0; sq_tid = '0; sq_seq = '0;
        sq_kind = '0; sq_target = '0; sq_pc = '0; trap_vld = 0; trap_tid = 0; trap_pc = 0;
        act_vld = 0; act_tid = 0; act_pc = 0; deact_vld = 0; deact_tid = 0;
        x_en = 0; x_seq_en = 0; x_unb_en = 0; x_req = "";
    endtask

    task automatic predict();
        string lab;
        logic [S*T-1:0] eb, eu;
        for (int t = 0; t < T; t++) begin ehit[t] = 0; elane[t] = 0; ebest[t] = 0; end
        for (int l = 0; l < L; l++)
            if (sq_vld[l] && (!ehit[sq_tid[l]] || sq_seq[l] < ebest[sq_tid[l]])) begin
                ehit[sq_tid[l]] = 1; ebest[sq_tid[l]] = sq_seq[l]; elane[sq_tid[l]] = l;
            end
        efv = fetch_req && mval[fetch_tid] && !ehit[fetch_tid];
        lab = ehit[fetch_tid] ? "R12" : (!mval[fetch_tid] ? "R3" : "R2");
        chk(lab, fetch_vld, efv);
        chk(lab, fetch_stall, fetch_req && !efv);
        chk(lab, fetch_pc, efv ? mpc[fetch_tid] : 0);
        chk(lab, fetch_seq, efv ? mseq[fetch_tid] : 0);
        eb = '0;
        if (br_vld && br_ctrl && br_ret && !br_taken) eb[br_stage*T + br_tid] = 1'b1;
        chk("R4", blk_out, eb);
        chk("R5", sqo_vld, br_vld && br_ctrl && br_taken);
        if (sqo_vld) begin
            chk("R5", sqo_tid, br_tid); chk("R5", sqo_stage, br_stage); chk("R5", sqo_seq, br_seq);
        end
        eu = '0;
        for (int t = 0; t < T; t++)
            if (ehit[t] && sq_kind[elane[t]] != 2'd0) eu[mbst[t]*T + t] = 1'b1;
        chk("R8", unblk_out, eu);
        if (x_en) begin
            chk(x_req, fetch_vld, x_vld);
            if (x_vld) chk(x_req, fetch_pc, x_pc);
        end
        if (x_seq_en) chk(x_req, fetch_seq, x_seq);
        if (x_unb_en) chk(x_req, unblk_out, x_unb);
    endtask

    task automatic commit();
        if (efv) begin mpc[fetch_tid] += 4; mseq[fetch_tid] += 1; end
        if (br_vld && br_ctrl && br_ret && !br_taken) begin
            mval[br_tid] = 0; mbst[br_tid] = br_stage;
        end
        for (int t = 0; t < T; t++)
            if (ehit[t]) begin
                case (sq_kind[elane[t]])
                    2'd0: mval[t] = 0;
                    2'd1: begin mpc[t] = sq_target[elane[t]]; mval[t] = 1; end
                    default: begin mpc[t] = sq_pc[elane[t]] + 4; mval[t] = 1; end
                endcase
            end
        if (trap_vld) begin mpc[trap_tid] = trap_pc; mval[trap_tid] = 1; end
        if (act_vld) begin mpc[act_tid] = act_pc; mval[act_tid] = 1; end
        if (deact_vld) begin mval[deact_tid] = 0; mbst[deact_tid] = 0; end
    endtask

    task automatic cycle();
        #(CLK_P/4);
        predict();
        @(posedge clk);
        commit();
        @(negedge clk);
        clear_in();
    endtask

    task automatic fetch_exp(int tid, bit v, logic [PW-1:0] pc, string r);
        fetch_req = 1; fetch_tid = 2'(tid);
        x_en = 1; x_vld = v; x_pc = pc; x_req = r;
        cycle();
    endtask

    task automatic squash1(int lane, int tid, int seq, int kind, logic [PW-1:0] tgt, logic [PW-1:0] ipc);
        sq_vld[lane] = 1; sq_tid[lane] = 2'(tid); sq_seq[lane] = SW'(seq);
        sq_kind[lane] = 2'(kind); sq_target[lane] = tgt; sq_pc[lane] = ipc;
    endtask

    initial begin
        for (int t = 0; t < T; t++) begin mpc[t] = 0; mval[t] = 0; mseq[t] = 0; mbst[t] = 0; end
        clear_in();
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: nothing valid after reset
        for (int t = 0; t < T; t++) fetch_exp(t, 0, 0, "R1");
        // R2 / R13
        act_vld = 1; act_tid = 0; act_pc = 32'h1000; cycle();
        fetch_exp(0, 1, 32'h1000, "R2");
        fetch_exp(0, 1, 32'h1004, "R2");
        fetch_exp(0, 1, 32'h1008, "R2");
        act_vld = 1; act_tid = 1; act_pc = 32'h2000; cycle();
        x_seq_en = 1; x_seq = 0; fetch_exp(1, 1, 32'h2000, "R13");
        // R4: unpredicted return at stage 3
        br_vld = 1; br_tid = 0; br_stage = 3; br_ctrl = 1; br_ret = 1; br_taken = 0; cycle();
        fetch_exp(0, 0, 0, "R4");
        // R8: control squash unblocks stage 3 of thread 0
        squash1(0, 0, 20, 1, 32'h4000, 0);
        x_unb_en = 1; x_unb = '0; x_unb[3*T+0] = 1'b1; x_req = "R8"; cycle();
        fetch_exp(0, 1, 32'h4000, "R8");
        // R6: oldest lane wins, tie goes to lane 0
        squash1(0, 0, 9, 1, 32'h5000, 0); squash1(1, 0, 5, 1, 32'h6000, 0); cycle();
        fetch_exp(0, 1, 32'h6000, "R6");
        squash1(0, 0, 7, 1, 32'h7000, 0); squash1(1, 0, 7, 1, 32'h7100, 0); cycle();
        fetch_exp(0, 1, 32'h7000, "R6");
        squash1(0, 0, 3, 1, 32'h7200, 0); squash1(1, 0, 4, 1, 32'h7300, 0); cycle();
        fetch_exp(0, 1, 32'h7200, "R6");
        // R12 then R9
        squash1(0, 0, 11, 2, 0, 32'h8000);
        fetch_exp(0, 0, 0, "R12");
        fetch_exp(0, 1, 32'h8004, "R9");
        // R7: fault squash
        squash1(1, 0, 12, 0, 0, 0);
        x_unb_en = 1; x_unb = '0; x_req = "R7"; cycle();
        fetch_exp(0, 0, 0, "R7");
        // R10: trap
        trap_vld = 1; trap_tid = 0; trap_pc = 32'h9000; cycle();
        fetch_exp(0, 1, 32'h9000, "R10");
        // R5: taken branch and non-control report
        br_vld = 1; br_tid = 1; br_stage = 2; br_seq = 16'h33; br_ctrl = 1; br_taken = 1; cycle();
        br_vld = 1; br_tid = 1; br_stage = 2; br_ctrl = 0; br_ret = 1; br_taken = 1; cycle();
        // R11: block at stage 4, deactivate, then squash unblocks stage 0
        br_vld = 1; br_tid = 1; br_stage = 4; br_ctrl = 1; br_ret = 1; cycle();
        deact_vld = 1; deact_tid = 1; cycle();
        fetch_exp(1, 0, 0, "R11");
        squash1(0, 1, 2, 2, 0, 32'hA000);
        x_unb_en = 1; x_unb = '0; x_unb[0*T+1] = 1'b1; x_req = "R11"; cycle();
        fetch_exp(1, 1, 32'hA004, "R11");
        // random phase
        for (int t = 0; t < T; t++) begin
            act_vld = 1; act_tid = 2'(t); act_pc = PW'(t) << 16; cycle();
        end
        for (int i = 0; i < 3000; i++) begin
            fetch_req = ($urandom % 4) != 0; fetch_tid = 2'($urandom);
            if (($urandom % 10) < 3) begin
                br_vld = 1; br_tid = 2'($urandom); br_stage = 3'($urandom % S);
                br_seq = SW'($urandom); br_ctrl = 1'($urandom); br_ret = 1'($urandom);
                br_taken = 1'($urandom);
            end
            for (int l = 0; l < L; l++)
                if (($urandom % 5) == 0)
                    squash1(l, int'($urandom % T), int'($urandom % 16), int'($urandom % 4),
                            {$urandom, 2'b00}, {$urandom, 2'b00});
            if (($urandom % 20) == 0) begin trap_vld = 1; trap_tid = 2'($urandom); trap_pc = {$urandom, 2'b00}; end
            if (($urandom % 20) == 0) begin act_vld = 1; act_tid = 2'($urandom); act_pc = {$urandom, 2'b00}; end
            if (($urandom % 33) == 0) begin deact_vld = 1; deact_tid = 2'($urandom); end
            cycle();
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule